// File: doc/BRIEF.md
# Dual Fixed-Pattern Serial Detector

This block watches a one-bit serial stream and raises one of two flags when the most recent four accepted bits form one of two fixed words. Each accepted bit moves into a left-shifting serial-in parallel-out register at the low end, and the oldest bit leaves from the top. A word written left to right therefore arrives in that same order. The two flags do not come from a state machine. Each is a plain AND of true or inverted register bits, one decoder per word, so the two words are watched in parallel and independently.

A shift-enable input gates which bits are accepted. While it is low, the register keeps its contents and the flags keep following those contents. The register can reset to a non-zero word. For that reason a small fill counter holds both flags low until four bits have been accepted since reset, so a match on leftover reset contents is never reported. Matches overlap fully: a bit that completes one match can also begin the next.

Top module: `seq_pair_detector`

## Requirements
- R1: While `rst` is high at a clock edge, `window` loads the reset word 4'b0101, and both `hit_a` and `hit_b` are 0 afterwards.
- R2: At a clock edge with `shift_en` high, `window` becomes its old bits [2:0] with `ser_in` appended at bit 0. Bit 3 holds the oldest bit.
- R3: At a clock edge with `shift_en` low, `window` keeps its value, and the flags keep reflecting that held value.
- R4: Once qualified, `hit_a` is 1 exactly when `window` equals 4'b1010 (bit 3 = 1, bit 0 = 0).
- R5: Once qualified, `hit_b` is 1 exactly when `window` equals 4'b1100.
- R6: Neither flag asserts until four bits have been accepted with `shift_en` high since the last reset. Cycles with `shift_en` low do not advance this count.
- R7: Detection overlaps: the accepted stream 1,0,1,0,1,0 raises `hit_a` after both the fourth and the sixth bit.
- R8: `hit_a` and `hit_b` are never high in the same cycle.
- R9: The flags are combinational from the register. A flag is valid in the cycle that follows the edge that accepted the completing bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| shift_en | input | 1 | Accept `ser_in` at this edge when high |
| window | output | 4 | Parallel register contents, bit 3 oldest |
| hit_a | output | 1 | Register holds 1010 and is qualified |
| hit_b | output | 1 | Register holds 1100 and is qualified |

## Verification
The hardest case to reach from the ports is a match that forms before the register has been filled, because only a non-zero reset word makes one possible. The stimulus resets the block and then shifts a single 0, which turns 0101 into 1010 after one accepted bit. It then idles `shift_en` before and between further shifts, to show that the fill count advances only on accepted bits. An overlapped 101010 run and a held match complete the vector table.

// File: rtl/patdet_pkg.sv
package patdet_pkg;
   localparam int unsigned DEF_WIDTH = 4;
   localparam logic [DEF_WIDTH-1:0] DEF_PAT_A = 4'b1010;
   localparam logic [DEF_WIDTH-1:0] DEF_PAT_B = 4'b1100;
   localparam logic [DEF_WIDTH-1:0] DEF_INIT  = 4'b0101;
endpackage

// File: rtl/patdet_sipo.sv
module patdet_sipo #(
   parameter int unsigned          WIDTH = 4,
   parameter logic [WIDTH-1:0]     INIT  = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_in,
   input  logic             shift_en,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 2) begin : g_bad_width
      $error("patdet_sipo: WIDTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)
         q <= INIT;
      else if (shift_en)
         q <= {q[WIDTH-2:0], ser_in};
   end

   assert_reset_load_R1: assert property (@(posedge clk) rst |=> (q == INIT));
   assert_new_bit_low_R2: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (q[0] == $past(ser_in)));
   assert_bits_move_up_R2: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));
   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(q));
endmodule

// File: rtl/patdet_fill.sv
module patdet_fill #(
   parameter int unsigned WIDTH   = 4,
   parameter bit          QUALIFY = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output logic armed
);
   localparam int unsigned CW = $clog2(WIDTH + 1);
   localparam logic [CW-1:0] FULL = CW'(WIDTH);

   if (QUALIFY) begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst)
            cnt <= '0;
         else if (step && (cnt != FULL))
            cnt <= cnt + 1'b1;
      end
      assign armed = (cnt == FULL);

      assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
         cnt <= FULL);
      assert_idle_no_count_R6: assert property (@(posedge clk) disable iff (rst)
         !step |=> $stable(cnt));
      assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
         armed |=> armed);
   end else begin : g_free
      logic unused_in;
      assign unused_in = step ^ rst ^ clk;
      assign armed = 1'b1;
   end
endmodule

// File: rtl/patdet_match.sv
module patdet_match #(
   parameter int unsigned      WIDTH = 4,
   parameter logic [WIDTH-1:0] PAT   = '0
) (
   input  logic [WIDTH-1:0] data,
   input  logic             qual,
   output logic             hit
);
   logic [WIDTH-1:0] term;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (PAT[i]) begin : g_true
         assign term[i] = data[i];
      end else begin : g_inv
         assign term[i] = ~data[i];
      end
   end

   assign hit = qual & (&term);
endmodule

// File: rtl/seq_pair_detector.sv
module seq_pair_detector
   import patdet_pkg::*;
#(
   parameter int unsigned      WIDTH   = DEF_WIDTH,
   parameter logic [WIDTH-1:0] PAT_A   = DEF_PAT_A,
   parameter logic [WIDTH-1:0] PAT_B   = DEF_PAT_B,
   parameter logic [WIDTH-1:0] INIT    = DEF_INIT,
   parameter bit               QUALIFY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_in,
   input  logic             shift_en,
   output logic [WIDTH-1:0] window,
   output logic             hit_a,
   output logic             hit_b
);
   if (PAT_A == PAT_B) begin : g_bad_pats
      $error("seq_pair_detector: the two patterns must differ");
   end

   logic armed;

   patdet_sipo #(.WIDTH(WIDTH), .INIT(INIT)) u_sipo (
      .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en), .q(window)
   );

   patdet_fill #(.WIDTH(WIDTH), .QUALIFY(QUALIFY)) u_fill (
      .clk(clk), .rst(rst), .step(shift_en), .armed(armed)
   );

   patdet_match #(.WIDTH(WIDTH), .PAT(PAT_A)) u_match_a (
      .data(window), .qual(armed), .hit(hit_a)
   );

   patdet_match #(.WIDTH(WIDTH), .PAT(PAT_B)) u_match_b (
      .data(window), .qual(armed), .hit(hit_b)
   );

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
      !(hit_a && hit_b));
   assert_quiet_unfilled_R6: assert property (@(posedge clk) disable iff (rst)
      !armed |-> (!hit_a && !hit_b));
   assert_pat_a_seen_R4: assert property (@(posedge clk) disable iff (rst)
      (armed && (window == PAT_A)) |-> hit_a);
   assert_pat_b_seen_R5: assert property (@(posedge clk) disable iff (rst)
      (armed && (window == PAT_B)) |-> hit_b);
   assert_hold_flags_R3: assert property (@(posedge clk) disable iff (rst)
      (armed && !shift_en) |=> ($stable(hit_a) && $stable(hit_b)));
endmodule

// File: tb/tb_seq_pair_detector.sv
module tb_seq_pair_detector;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ser_in = 1'b0;
   logic       shift_en = 1'b0;
   logic [3:0] window;
   logic       hit_a, hit_b;
   int         errors = 0;
   int         checks = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   seq_pair_detector dut (
      .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en),
      .window(window), .hit_a(hit_a), .hit_b(hit_b)
   );

   // entry: [7] shift_en, [6] ser_in, [5:2] expected window, [1] hit_a, [0] hit_b
   localparam int NVEC = 19;
   localparam logic [7:0] VEC [NVEC] = '{
      8'b1_0_1010_0_0,   // R6 reset word shifted once: 1010 but not qualified
      8'b1_1_0101_0_0,   // R2
      8'b1_1_1011_0_0,   // R2
      8'b1_0_0110_0_0,   // fourth accepted bit, qualified now
      8'b1_0_1100_0_1,   // R5 R9
      8'b0_1_1100_0_1,   // R3 hold keeps flag
      8'b1_1_1001_0_0,
      8'b1_0_0010_0_0,
      8'b1_1_0101_0_0,
      8'b1_0_1010_1_0,   // R4
      8'b1_1_0101_0_0,
      8'b1_0_1010_1_0,   // R7 overlapped second hit
      8'b0_0_1010_1_0,   // R3
      8'b1_0_0100_0_0,
      8'b1_1_1001_0_0,
      8'b1_1_0011_0_0,
      8'b1_0_0110_0_0,
      8'b1_0_1100_0_1,   // R5 R8
      8'b1_0_1000_0_0
   };

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(input logic en, input logic d);
      shift_en = en;
      ser_in   = d;
      @(negedge clk);
   endtask

   task automatic summary;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk("R1 window", window, 4'b0101);
      chk("R1 flags", {2'b00, hit_a, hit_b}, 4'b0000);

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][7], VEC[i][6]);
         chk($sformatf("R2/R3 window step %0d", i), window, VEC[i][5:2]);
         chk($sformatf("R4/R7 hit_a step %0d", i), {3'b000, hit_a}, {3'b000, VEC[i][1]});
         chk($sformatf("R5/R8 hit_b step %0d", i), {3'b000, hit_b}, {3'b000, VEC[i][0]});
      end

      // reset mid-stream restores the reset word and disarms the flags
      rst = 1'b1;
      step(1'b1, 1'b1);
      rst = 1'b0;
      chk("R1 window after mid reset", window, 4'b0101);
      chk("R1 flags after mid reset", {2'b00, hit_a, hit_b}, 4'b0000);

      // idle cycles must not count toward qualification (R6)
      repeat (3) step(1'b0, 1'b1);
      chk("R3 window idle", window, 4'b0101);
      step(1'b1, 1'b0);
      chk("R6 window", window, 4'b1010);
      chk("R6 no hit after 1 bit", {3'b000, hit_a}, 4'b0000);
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      chk("R6 window after 3 bits", window, 4'b1010);
      chk("R6 no hit after 3 bits", {3'b000, hit_a}, 4'b0000);
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      chk("R9 window after 5 bits", window, 4'b1010);
      chk("R9 hit_a after qualification", {3'b000, hit_a}, 4'b0001);
      chk("R8 hit_b low", {3'b000, hit_b}, 4'b0000);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule